// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

The block turns a selectable source clock into a master clock and a serial bit clock for two independent audio directions, transmit and receive. Everything runs on one system clock, `clk_i`. The two source clocks arrive as single-cycle enables, `src_a_i` and `src_b_i`. Each enable pulse is one source tick.

Each direction has its own chain:
- an optional divide-by-8 prescaler;
- a modulus stage that divides by 1 to 256;
- a fixed toggle stage that divides by 2 and forms the master clock;
- a bit-clock stage that divides the master clock by 1 to 16.

Source A can also bypass every master-clock stage. In that case each source-A tick becomes one master-clock pulse, and the bit clock is derived from those ticks by the last stage alone.

Software writes a 20-bit configuration word into a per-direction shadow register. The divider, source, bypass and polarity fields move to the working copy only at the end of a bit-clock period. This keeps runt pulses off both clock outputs. The pin-direction fields act at once.

Configuration word layout:

| Bits | Field |
|---|---|
| 0 | source select (0 = A, 1 = B) |
| 1 | full bypass |
| 2 | divide-by-8 prescaler enable |
| 10:3 | modulus minus one |
| 14:11 | bit divider minus one |
| 15 | master clock invert |
| 16 | bit clock invert |
| 17 | master clock pin drive |
| 18 | bit clock pin drive |
| 19 | frame sync pin drive |

In the requirements below, P is 8 when bit 2 is set and 1 otherwise, M is bits 10:3 plus one, and F is bits 14:11 plus one.

Top module: `audio_clk_div`

## Requirements
- R1: The state right after reset is as follows. All clock, strobe and drive outputs are 0. Both directions run the all-zero configuration: source A, no bypass, P=1, M=1, F=1.
- R2: Without bypass, the master clock toggles after every P*M selected source ticks. Its period is 2*P*M ticks with equal high and low phases.
- R3: When bit 2 is set, the prescaler makes P equal to 8, so the master clock half period is 8*M ticks.
- R4: Without bypass, the bit clock period is 2*P*M*F source ticks. It is high for the first half of the period and low for the second. The bit clock output changes only on a selected source tick.
- R5: With bit 1 set and source A selected, both the master clock output and its strobe are high in the cycle after each source-A tick. The bit clock period is then F ticks, high for (F+1)/2 of them, so odd F gives the longer high phase.
- R6: Bit 1 has no effect while source B is selected. The chain then behaves as in R2 and R4.
- R7: Only ticks of the selected source advance a direction's chain. The other source's ticks have no effect.
- R8: A written configuration (all fields except the drive bits) takes effect at the next bit clock rising edge, which ends a period. Until then, the outputs follow the previous configuration.
- R9: The three drive outputs of a direction equal bits 17, 18 and 19 of the last word written to it, from the cycle after the write.
- R10: Bits 15 and 16 invert the master clock output and the bit clock output.
- R11: Transmit (`cfg_ch_i`=0, output bit 0) and receive (`cfg_ch_i`=1, output bit 1) are independent. A write to one direction never alters the other.
- R12: A master strobe is high for one cycle with each rising edge of the uninverted master clock. A bit strobe is high with each rising edge of the uninverted bit clock. A bit strobe always coincides with a master strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| src_a_i | input | 1 | source A tick enable (bypass-capable) |
| src_b_i | input | 1 | source B tick enable |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_ch_i | input | 1 | target direction, 0 transmit, 1 receive |
| cfg_data_i | input | 20 | configuration word |
| mclk_o | output | 2 | master clock level per direction |
| mclk_stb_o | output | 2 | master clock rising strobe per direction |
| bclk_o | output | 2 | bit clock level per direction |
| bclk_stb_o | output | 2 | bit clock rising strobe per direction |
| mclk_oe_o | output | 2 | master clock pin drive per direction |
| bclk_oe_o | output | 2 | bit clock pin drive per direction |
| fs_oe_o | output | 2 | frame sync pin drive per direction |

## Verification
The assertions assume the following about the inputs:
- Source ticks and configuration writes are synchronous to `clk_i`.
- The source ticks are sampled exactly as driven, with no width or spacing constraint.

Given that, the assertions hold that divider counters never leave range and that the working configuration changes only at a period end. They also hold that, outside bypass, outputs move only on ticks.

The stimulus drives ticks from a shift-register pattern on both sources, including back-to-back ticks. Writes fall in mid-period, at period ends and between bypass and divided modes, so the deferred reload is exercised at every boundary.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned MOD_W     = 8;
  localparam int unsigned FP_W      = 4;
  localparam int unsigned PRE_RATIO = 8;
  localparam int unsigned CH_W      = $clog2(NCH);

  typedef struct packed {
    logic             fs_oe;
    logic             bclk_oe;
    logic             mclk_oe;
    logic             bclk_inv;
    logic             mclk_inv;
    logic [FP_W-1:0]  fp;
    logic [MOD_W-1:0] mod;
    logic             pre8;
    logic             bypass;
    logic             src_b;
  } acd_cfg_t;

  localparam int unsigned CFG_W = $bits(acd_cfg_t);
endpackage

// File: rtl/acd_cfg_reg.sv
module acd_cfg_reg
  import acd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  acd_cfg_t data_i,
  input  logic     load_i,
  output acd_cfg_t shadow_o,
  output acd_cfg_t active_o
);
  acd_cfg_t shadow_q, active_q;
  logic     pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (load_i && pend_q) active_q <= shadow_q;
      if (we_i) begin
        shadow_q <= data_i;
        pend_q   <= 1'b1;
      end else if (load_i) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R8: working copy moves only at a period end
  p_active_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_q));

  // R9: shadow reflects the last write
  p_shadow_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> shadow_q == $past(data_i));
endmodule

// File: rtl/acd_mclk_stage.sv
module acd_mclk_stage #(
  parameter int unsigned MOD_W     = acd_pkg::MOD_W,
  parameter int unsigned PRE_RATIO = acd_pkg::PRE_RATIO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pre8_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             bypass_i,
  output logic             unit_o,
  output logic             mclk_o,
  output logic             stb_o
);
  localparam int unsigned PRE_W = $clog2(PRE_RATIO);

  logic [PRE_W-1:0] pc_q;
  logic [MOD_W-1:0] mc_q;
  logic             mclk_q, stb_q;
  logic             pre_wrap, mod_wrap, t1, unit_norm;

  assign pre_wrap  = pc_q == PRE_W'(PRE_RATIO - 1);
  assign t1        = tick_i & (!pre8_i | pre_wrap);
  assign mod_wrap  = mc_q == mod_i;
  assign unit_norm = t1 & mod_wrap;
  assign unit_o    = bypass_i ? tick_i : unit_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mc_q   <= '0;
      mclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else if (bypass_i) begin
      mclk_q <= tick_i;
      stb_q  <= tick_i;
    end else begin
      if (tick_i && pre8_i) pc_q <= pre_wrap ? '0 : pc_q + 1'b1;
      if (t1) mc_q <= mod_wrap ? '0 : mc_q + 1'b1;
      stb_q <= unit_norm & !mclk_q;
      if (unit_norm) mclk_q <= !mclk_q;
    end
  end

  assign mclk_o = mclk_q;
  assign stb_o  = stb_q;

  // R2: modulus counter stays within the programmed range
  p_mod_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_q <= mod_i);

  // R7: no tick, no master clock movement outside bypass
  p_mclk_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !bypass_i) |=> $stable(mclk_q));

  // R12: a strobe marks a high master clock
  p_stb_high_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> mclk_q);
endmodule

// File: rtl/acd_bclk_stage.sv
module acd_bclk_stage #(
  parameter int unsigned FP_W = acd_pkg::FP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            unit_i,
  input  logic [FP_W-1:0] fp_i,
  input  logic            bypass_i,
  output logic            term_o,
  output logic            bclk_o,
  output logic            stb_o
);
  localparam int unsigned CW = FP_W + 1;

  logic [CW-1:0] bc_q, last;
  logic [CW:0]   fdiv, hi, bc_nx;
  logic          at_last, bclk_q, stb_q;

  // bypass counts source ticks (length F), else master half periods (2F)
  assign last    = bypass_i ? CW'(fp_i) : {fp_i, 1'b1};
  assign fdiv    = (CW+1)'(fp_i) + 1'b1;
  assign hi      = bypass_i ? ((fdiv + 1'b1) >> 1) : fdiv;
  assign bc_nx   = {1'b0, bc_q} + 1'b1;
  assign at_last = bc_q >= last;
  assign term_o  = unit_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_q   <= '1;
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (unit_i) begin
        if (at_last) begin
          bc_q   <= '0;
          bclk_q <= 1'b1;
          stb_q  <= 1'b1;
        end else begin
          bc_q   <= bc_nx[CW-1:0];
          bclk_q <= bc_nx < hi;
        end
      end
    end
  end

  assign bclk_o = bclk_q;
  assign stb_o  = stb_q;

  // R4: bit clock moves only on a stage unit
  p_bclk_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_i |=> ($stable(bclk_q) && !stb_q));
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import acd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_a_i,
  input  logic             src_b_i,
  input  logic             cfg_we_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic [NCH-1:0]   mclk_o,
  output logic [NCH-1:0]   mclk_stb_o,
  output logic [NCH-1:0]   bclk_o,
  output logic [NCH-1:0]   bclk_stb_o,
  output logic [NCH-1:0]   mclk_oe_o,
  output logic [NCH-1:0]   bclk_oe_o,
  output logic [NCH-1:0]   fs_oe_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    acd_cfg_t shadow, active;
    logic     we, tick, byp, unit, term, mclk_raw, mstb, bclk_raw, bstb;

    assign we   = cfg_we_i && (cfg_ch_i == CH_W'(c));
    assign tick = active.src_b ? src_b_i : src_a_i;
    assign byp  = active.bypass & !active.src_b;

    acd_cfg_reg u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we),
      .data_i   (acd_cfg_t'(cfg_data_i)),
      .load_i   (term),
      .shadow_o (shadow),
      .active_o (active)
    );

    acd_mclk_stage #(.MOD_W(MOD_W), .PRE_RATIO(PRE_RATIO)) u_mclk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .pre8_i   (active.pre8),
      .mod_i    (active.mod),
      .bypass_i (byp),
      .unit_o   (unit),
      .mclk_o   (mclk_raw),
      .stb_o    (mstb)
    );

    acd_bclk_stage #(.FP_W(FP_W)) u_bclk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .unit_i   (unit),
      .fp_i     (active.fp),
      .bypass_i (byp),
      .term_o   (term),
      .bclk_o   (bclk_raw),
      .stb_o    (bstb)
    );

    assign mclk_o[c]     = mclk_raw ^ active.mclk_inv;
    assign bclk_o[c]     = bclk_raw ^ active.bclk_inv;
    assign mclk_stb_o[c] = mstb;
    assign bclk_stb_o[c] = bstb;
    assign mclk_oe_o[c]  = shadow.mclk_oe;
    assign bclk_oe_o[c]  = shadow.bclk_oe;
    assign fs_oe_o[c]    = shadow.fs_oe;

    // R12: bit clock edges sit on master clock edges
    p_bclk_on_mclk_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bstb |-> mstb);
  end
endmodule

// File: tb/audio_clk_div_tb.sv
module audio_clk_div_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        src_a = 1'b0, src_b = 1'b0, we = 1'b0;
  logic [0:0]  wch = 1'b0;
  logic [19:0] wd = '0;
  logic [1:0]  mclk, mstb, bclk, bstb, moe, boe, foe;

  audio_clk_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(src_a), .src_b_i(src_b),
    .cfg_we_i(we), .cfg_ch_i(wch), .cfg_data_i(wd),
    .mclk_o(mclk), .mclk_stb_o(mstb), .bclk_o(bclk), .bclk_stb_o(bstb),
    .mclk_oe_o(moe), .bclk_oe_o(boe), .fs_oe_o(foe)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  logic [19:0] m_sh [2], m_act [2];
  bit  m_pend [2];
  int  m_ph [2];
  bit  e_m [2], e_b [2], e_ms [2], e_bs [2];

  function automatic bit f_byp(logic [19:0] c); return c[1] & ~c[0]; endfunction
  function automatic int f_pm(logic [19:0] c);
    return (c[2] ? 8 : 1) * (int'(c[10:3]) + 1);
  endfunction
  function automatic int f_f(logic [19:0] c); return int'(c[14:11]) + 1; endfunction
  function automatic int f_per(logic [19:0] c);
    return f_byp(c) ? f_f(c) : 2 * f_pm(c) * f_f(c);
  endfunction
  function automatic logic [19:0] mk(bit src, bit byp, bit pre, int md, int fp,
                                     bit mi, bit bi, bit mo, bit bo, bit fo);
    return {fo, bo, mo, bi, mi, 4'(fp), 8'(md), pre, byp, src};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_sh[c] = '0; m_act[c] = '0; m_pend[c] = 0;
      m_ph[c] = f_per('0) - f_pm('0);
      e_m[c] = 0; e_b[c] = 0; e_ms[c] = 0; e_bs[c] = 0;
    end
  endtask

  task automatic model_step(bit ta, bit tb, bit w, bit wc, logic [19:0] d);
    for (int c = 0; c < 2; c++) begin
      bit tk = m_act[c][0] ? tb : ta;
      e_ms[c] = 0; e_bs[c] = 0;
      if (f_byp(m_act[c])) e_m[c] = 0;
      if (tk) begin
        m_ph[c]++;
        if (m_ph[c] >= f_per(m_act[c])) begin
          if (m_pend[c]) begin m_act[c] = m_sh[c]; m_pend[c] = 0; end
          m_ph[c] = 0;
        end
        if (f_byp(m_act[c])) begin
          e_m[c] = 1; e_ms[c] = 1;
          e_b[c] = m_ph[c] < (f_f(m_act[c]) + 1) / 2;
        end else begin
          int u = f_pm(m_act[c]);
          e_m[c]  = ((m_ph[c] / u) % 2) == 0;
          e_ms[c] = (m_ph[c] % (2 * u)) == 0;
          e_b[c]  = m_ph[c] < f_per(m_act[c]) / 2;
        end
        e_bs[c] = m_ph[c] == 0;
      end
      if (w && (int'(wc) == c)) begin m_sh[c] = d; m_pend[c] = 1; end
    end
  endtask

  task automatic chk(string req, string nm, int c, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s ch%0d t=%0t actual=%0b expected=%0b", req, nm, c, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      chk(cur_req, "mclk", c, mclk[c], e_m[c] ^ m_act[c][15]);
      chk(cur_req, "bclk", c, bclk[c], e_b[c] ^ m_act[c][16]);
      chk("R12", "mclk_stb", c, mstb[c], e_ms[c]);
      chk("R12", "bclk_stb", c, bstb[c], e_bs[c]);
      chk("R9", "mclk_oe", c, moe[c], m_sh[c][17]);
      chk("R9", "bclk_oe", c, boe[c], m_sh[c][18]);
      chk("R9", "fs_oe", c, foe[c], m_sh[c][19]);
    end
  endtask

  task automatic cyc(bit ta, bit tb, bit w, bit wc, logic [19:0] d);
    @(negedge clk);
    compare_all();
    src_a = ta; src_b = tb; we = w; wch = wc; wd = d;
    model_step(ta, tb, w, wc, d);
  endtask

  // density: 0 = every cycle on A, 1 = pseudo-random on both sources
  task automatic run(int n, int dens);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (dens == 0) cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
      else cyc(lfsr[0], lfsr[3], 1'b0, 1'b0, '0);
    end
  endtask

  task automatic wr(bit c, logic [19:0] d);
    cyc(lfsr[1], lfsr[4], 1'b1, c, d);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1'b1;
    run(40, 0);
    cur_req = "R7";
    run(80, 1);
    cur_req = "R2";
    wr(0, mk(0, 0, 0, 2, 1, 0, 0, 1, 0, 0));
    wr(1, mk(1, 0, 0, 4, 0, 0, 0, 0, 1, 1));
    run(400, 1);
    cur_req = "R3";
    wr(0, mk(0, 0, 1, 1, 2, 0, 0, 0, 0, 1));
    wr(1, mk(0, 0, 1, 0, 3, 0, 0, 1, 1, 0));
    run(1500, 0);
    cur_req = "R4";
    wr(0, mk(0, 0, 0, 0, 15, 0, 0, 0, 0, 0));
    run(500, 1);
    cur_req = "R5";
    wr(0, mk(0, 1, 0, 0, 4, 0, 0, 1, 1, 1));
    wr(1, mk(0, 1, 0, 0, 1, 0, 0, 0, 0, 0));
    run(300, 1);
    run(60, 0);
    cur_req = "R6";
    wr(1, mk(1, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    run(300, 1);
    cur_req = "R10";
    wr(0, mk(0, 0, 0, 1, 1, 1, 1, 0, 0, 0));
    wr(1, mk(1, 0, 0, 0, 2, 1, 0, 0, 0, 0));
    run(300, 1);
    cur_req = "R8";
    for (int k = 0; k < 12; k++) begin
      wr(k[0], mk(k[1], k[2], k[3] & k[0], k % 3, (k * 5) % 16, k[2], k[1], 0, 0, 0));
      run(7 + k, 1);
      wr(k[0], mk(0, k[1], 0, k % 2, k % 7, 0, k[0], 1, 0, 1));
      run(40, 0);
    end
    cur_req = "R11";
    wr(0, mk(0, 0, 0, 3, 2, 0, 0, 1, 1, 1));
    run(200, 1);
    wr(1, mk(0, 1, 0, 0, 6, 0, 1, 0, 1, 0));
    run(200, 1);
    cur_req = "R9";
    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    run(5, 1);
    wr(1, mk(1, 0, 0, 0, 0, 0, 0, 1, 0, 1));
    run(5, 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule